// File: doc/BRIEF.md
# Punctured Serial Concatenated Convolutional Encoder

This block turns one block of information bits into a punctured serially concatenated convolutional codeword. An outer recursive systematic convolutional encoder produces a codeword that is optionally punctured to rate 2/3. An interleaver reorders it. An identical inner encoder then produces a systematic stream and a parity stream, plus two trellis-closing steps. The systematic stream is thinned by a periodic keep mask. The parity stream is thinned by a fractional accumulator, so the overall code rate can be set finely. The result leaves as a serial bit stream with a valid strobe, ready for a symbol mapper.

A block starts with a one-cycle `start` pulse. On that pulse the block size, outer mode, interleaver stride, systematic mask, parity keep-ratio and the information bits are captured. The encoder stays busy until the last output bit has left. Only then is the next `start` taken, and it may arrive in the very cycle `busy` is low. The pattern choices and the mapping belong to the surrounding design.

Top module: `sccc_encoder`

## Requirements
- R1: While reset is held and right after its release, `busy` and `out_valid` are 0.
- R2: Both constituent encoders start each block in state 0. They use the 4-state recursive systematic code with feedback 1+D+D^2 and forward polynomial 1+D^2: with state bits s1 (newest) and s2, a = u^s1^s2, parity = a^s2, next s1 = a and next s2 = s1.
- R3: Outer codeword order per information bit t (taken from `info_bits[t]`, t = 0 first) is the systematic bit, then its parity bit. With `cfg_outer_full`=0, the parity is kept only for even t, so N = k + ceil(k/2). With `cfg_outer_full`=1, every parity bit is kept, so N = 2k.
- R4: The j-th inner input bit is the outer codeword bit at address a_j, with a_0 = 0 and a_(j+1) = (a_j + `cfg_stride`) mod N. The stride must be coprime to N with 1 <= stride < N, and k must be at least 2.
- R5: For each inner step the systematic bit is emitted before the parity bit. A bit that is dropped produces no `out_valid` pulse. Each step takes two cycles.
- R6: For inner steps j < N, the systematic bit is sent only when `cfg_sys_mask[j mod MASK_LEN]` is 1. The mask index wraps every MASK_LEN steps.
- R7: After the N data steps, two closing steps feed u = s1^s2, which drives the inner state back to 0. Their systematic bits are always sent, whatever the mask says.
- R8: The parity accumulator starts each block at 0. For every inner step j = 0..N+1 it forms sum = acc + `cfg_keep_ratio`. The parity bit is kept when sum >= 2^ACC_W, and acc then becomes sum mod 2^ACC_W.
- R9: `busy` rises the cycle after an accepted `start` and stays high for exactly k + 2(N+2) cycles. A `start` pulse or any configuration or data change while busy has no effect on the block in progress.
- R10: A `start` presented in the first cycle `busy` is low is accepted, so blocks can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block; honoured only when not busy |
| cfg_k_len | input | KW | Number of information bits k (2..MAX_K) |
| cfg_outer_full | input | 1 | 1: outer parity unpunctured; 0: outer rate 2/3 |
| cfg_stride | input | NW | Interleaver address increment |
| cfg_sys_mask | input | MASK_LEN | Periodic systematic keep mask, 1 = send |
| cfg_keep_ratio | input | ACC_W | Parity keep fraction in units of 2^-ACC_W |
| info_bits | input | MAX_K | Information bits, bit 0 encoded first |
| busy | output | 1 | Block in progress |
| out_valid | output | 1 | `out_bit` carries a code bit this cycle |
| out_bit | output | 1 | Serial code bit |

## Verification
The hardest situation to reach from the ports is wrap-around of the systematic mask index. It needs an interleaved codeword longer than the 300-position mask period. The stimulus uses near-maximum block sizes in the unpunctured outer mode (N = 500 and N = 384), with a pseudo-random mask whose second period must line up exactly. The two closing steps are isolated with an all-zero mask and a zero keep-ratio, so that only they can produce output. A sweep of small block sizes in both outer modes then covers the odd-length rate-2/3 tail, the coprime-stride interleaver and the accumulator phases. Mid-block start pulses and scrambled inputs check that the block in progress keeps the configuration it captured.

// File: rtl/sccc_pkg.sv
`timescale 1ns/1ps
package sccc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OUTER = 2'd1,
    ST_INNER = 2'd2
  } sccc_state_e;
endpackage

// File: rtl/sccc_rsc.sv
`timescale 1ns/1ps
// 4-state recursive systematic constituent encoder (feedback 7, forward 5 octal)
module sccc_rsc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       en,
  input  logic       u,
  output logic       p,
  output logic [1:0] st
);
  logic [1:0] st_q, st_d;
  logic       fb;

  always_comb begin
    fb   = u ^ st_q[0] ^ st_q[1];
    p    = fb ^ st_q[1];
    st_d = st_q;
    if (clr)     st_d = 2'b00;
    else if (en) st_d = {st_q[0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= 2'b00;
    else        st_q <= st_d;
  end

  assign st = st_q;
endmodule

// File: rtl/sccc_ileave_addr.sv
`timescale 1ns/1ps
// Interleaver read-address generator: a(j+1) = (a(j) + stride) mod n
module sccc_ileave_addr #(
  parameter int NW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [NW-1:0] n_len,
  input  logic [NW-1:0] stride,
  output logic [NW-1:0] addr
);
  logic [NW-1:0] addr_q, addr_d;
  logic [NW:0]   sum;

  always_comb begin
    sum = {1'b0, addr_q} + {1'b0, stride};
    if (sum >= {1'b0, n_len}) sum = sum - {1'b0, n_len};
    addr_d = addr_q;
    if (clr)     addr_d = '0;
    else if (en) addr_d = sum[NW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;
endmodule

// File: rtl/sccc_ratematch.sv
`timescale 1ns/1ps
// Fractional accumulator: keep a parity bit on every carry out
module sccc_ratematch #(
  parameter int ACC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [ACC_W-1:0] ratio,
  output logic             keep
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, ratio};
    keep  = sum[ACC_W];
    acc_d = acc_q;
    if (clr)     acc_d = '0;
    else if (en) acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/sccc_encoder.sv
`timescale 1ns/1ps
module sccc_encoder
  import sccc_pkg::*;
#(
  parameter int MAX_K    = 256,
  parameter int MASK_LEN = 300,
  parameter int ACC_W    = 8,
  localparam int MAX_N   = 2 * MAX_K,
  localparam int KW      = $clog2(MAX_K + 1),
  localparam int NW      = $clog2(MAX_N + 3),
  localparam int MW      = $clog2(MASK_LEN)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [KW-1:0]       cfg_k_len,
  input  logic                cfg_outer_full,
  input  logic [NW-1:0]       cfg_stride,
  input  logic [MASK_LEN-1:0] cfg_sys_mask,
  input  logic [ACC_W-1:0]    cfg_keep_ratio,
  input  logic [MAX_K-1:0]    info_bits,
  output logic                busy,
  output logic                out_valid,
  output logic                out_bit
);
  sccc_state_e         state_q, state_d;
  logic [KW-1:0]       k_q, t_q, t_d;
  logic                full_q;
  logic [NW-1:0]       stride_q, wp_q, wp_d, n_q, n_d, step_q, step_d;
  logic [MASK_LEN-1:0] mask_q;
  logic [ACC_W-1:0]    ratio_q;
  logic [MAX_K-1:0]    info_q;
  logic                sub_q, sub_d;
  logic [MW-1:0]       midx_q, midx_d;
  logic [MAX_N-1:0]    cw_q;

  logic cap, outer_en, adv, term;
  logic outer_u, outer_p, outer_keep_p, inner_u, inner_p, rm_keep;
  logic [1:0]    outer_st, inner_st;
  logic [NW-1:0] il_addr;

  // outer encoder
  assign outer_u      = info_q[t_q];
  assign outer_keep_p = full_q | ~t_q[0];

  sccc_rsc u_outer (
    .clk(clk), .rst_n(rst_n), .clr(cap), .en(outer_en),
    .u(outer_u), .p(outer_p), .st(outer_st)
  );

  // inner path
  assign term    = (step_q >= n_q);
  assign inner_u = term ? (inner_st[0] ^ inner_st[1]) : cw_q[il_addr];

  sccc_rsc u_inner (
    .clk(clk), .rst_n(rst_n), .clr(cap), .en(adv),
    .u(inner_u), .p(inner_p), .st(inner_st)
  );

  sccc_ileave_addr #(.NW(NW)) u_ileave (
    .clk(clk), .rst_n(rst_n), .clr(cap), .en(adv & ~term),
    .n_len(n_q), .stride(stride_q), .addr(il_addr)
  );

  sccc_ratematch #(.ACC_W(ACC_W)) u_ratematch (
    .clk(clk), .rst_n(rst_n), .clr(cap), .en(adv),
    .ratio(ratio_q), .keep(rm_keep)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    t_d       = t_q;
    wp_d      = wp_q;
    n_d       = n_q;
    step_d    = step_q;
    sub_d     = sub_q;
    midx_d    = midx_q;
    cap       = 1'b0;
    outer_en  = 1'b0;
    adv       = 1'b0;
    out_valid = 1'b0;
    out_bit   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          cap     = 1'b1;
          state_d = ST_OUTER;
          t_d     = '0;
          wp_d    = '0;
        end
      end
      ST_OUTER: begin
        outer_en = 1'b1;
        wp_d     = wp_q + (outer_keep_p ? NW'(2) : NW'(1));
        t_d      = t_q + KW'(1);
        if (t_q == k_q - KW'(1)) begin
          state_d = ST_INNER;
          n_d     = wp_d;
          step_d  = '0;
          sub_d   = 1'b0;
          midx_d  = '0;
        end
      end
      ST_INNER: begin
        if (!sub_q) begin
          out_valid = term | mask_q[midx_q];
          out_bit   = inner_u;
          sub_d     = 1'b1;
        end else begin
          out_valid = rm_keep;
          out_bit   = inner_p;
          sub_d     = 1'b0;
          adv       = 1'b1;
          step_d    = step_q + NW'(1);
          midx_d    = (midx_q == MW'(MASK_LEN - 1)) ? '0 : midx_q + MW'(1);
          if (step_q == n_q + NW'(1)) state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign busy = (state_q != ST_IDLE);

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      t_q     <= '0;
      wp_q    <= '0;
      n_q     <= '0;
      step_q  <= '0;
      sub_q   <= 1'b0;
      midx_q  <= '0;
    end else begin
      state_q <= state_d;
      t_q     <= t_d;
      wp_q    <= wp_d;
      n_q     <= n_d;
      step_q  <= step_d;
      sub_q   <= sub_d;
      midx_q  <= midx_d;
    end
  end

  // configuration capture, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      k_q      <= '0;
      full_q   <= 1'b0;
      stride_q <= '0;
      mask_q   <= '0;
      ratio_q  <= '0;
      info_q   <= '0;
    end else if (cap) begin
      k_q      <= cfg_k_len;
      full_q   <= cfg_outer_full;
      stride_q <= cfg_stride;
      mask_q   <= cfg_sys_mask;
      ratio_q  <= cfg_keep_ratio;
      info_q   <= info_bits;
    end
  end

  // outer codeword storage (no reset: written before read)
  always_ff @(posedge clk) begin
    if (outer_en) begin
      cw_q[wp_q] <= outer_u;
      if (outer_keep_p) cw_q[wp_q + NW'(1)] <= outer_p;
    end
  end

  // assertions
  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);

  a_r2_outer_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OUTER && t_q == '0) |-> (outer_st == 2'b00));

  a_r3_outer_length: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INNER && $past(state_q) == ST_OUTER) |->
      (n_q == (full_q ? ({{(NW-KW){1'b0}}, k_q} << 1)
                      : {{(NW-KW){1'b0}}, k_q} + (({{(NW-KW){1'b0}}, k_q} + NW'(1)) >> 1))));

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INNER && !term) |-> (il_addr < n_q));

  a_r7_term_sent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INNER && !sub_q && term) |-> out_valid);

  a_r7_state_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_INNER && sub_q && step_q == n_q + NW'(1)) |=> (inner_st == 2'b00));

  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(k_q) && $stable(stride_q) && $stable(ratio_q)));
endmodule

// File: tb/sccc_encoder_bench.sv
`timescale 1ns/1ps
module sccc_encoder_bench;
  localparam int MAX_K = 256;
  localparam int MASK_LEN = 300;
  localparam int ACC_W = 8;
  localparam int KW = $clog2(MAX_K + 1);
  localparam int NW = $clog2(2 * MAX_K + 3);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [KW-1:0] cfg_k_len = '0;
  logic cfg_outer_full = 1'b0;
  logic [NW-1:0] cfg_stride = '0;
  logic [MASK_LEN-1:0] cfg_sys_mask = '0;
  logic [ACC_W-1:0] cfg_keep_ratio = '0;
  logic [MAX_K-1:0] info_bits = '0;
  logic busy, out_valid, out_bit;

  always #2.5 clk = ~clk;

  sccc_encoder u_sccc_encoder (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_k_len(cfg_k_len),
    .cfg_outer_full(cfg_outer_full), .cfg_stride(cfg_stride),
    .cfg_sys_mask(cfg_sys_mask), .cfg_keep_ratio(cfg_keep_ratio),
    .info_bits(info_bits), .busy(busy), .out_valid(out_valid), .out_bit(out_bit)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bit got [0:1199];
  bit expv[0:1199];
  bit cw  [0:599];
  int gcnt = 0;
  int ecnt = 0;
  int bcnt = 0;
  int lcg = 12345;

  always @(negedge clk) begin
    if (out_valid) begin
      if (gcnt < 1200) got[gcnt] = out_bit;
      gcnt++;
    end
    if (busy) bcnt++;
  end

  function automatic int nextr();
    lcg = (lcg * 1103515245 + 12345) & 32'h7fffffff;
    return lcg >>> 8;
  endfunction

  function automatic int gcd(int a, int b);
    while (b != 0) begin
      int r = a % b;
      a = b;
      b = r;
    end
    return a;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // mask_kind: 0 all zero, 1 all one, 2 pseudo random; poke: mid-block start and input scramble
  task automatic run_block(int k, bit full, int want_stride, int ratio, int mask_kind, bit poke, string tag);
    bit [MAX_K-1:0] info;
    bit [MASK_LEN-1:0] mask;
    int n, stride, addr, acc, s1, s2;
    for (int i = 0; i < MAX_K; i++) info[i] = nextr() & 1;
    for (int i = 0; i < MASK_LEN; i++)
      mask[i] = (mask_kind == 0) ? 1'b0 : (mask_kind == 1) ? 1'b1 : ((nextr() % 3) != 0);
    // outer model (R2, R3)
    n = 0; s1 = 0; s2 = 0;
    for (int t = 0; t < k; t++) begin
      int u = info[t];
      int a = u ^ s1 ^ s2;
      int p = a ^ s2;
      s2 = s1; s1 = a;
      cw[n++] = u[0];
      if (full || (t % 2 == 0)) cw[n++] = p[0];
    end
    stride = want_stride % n;
    if (stride == 0) stride = 1;
    while (gcd(stride, n) != 1) stride++;
    // inner model (R4..R8)
    ecnt = 0; addr = 0; acc = 0; s1 = 0; s2 = 0;
    for (int j = 0; j < n + 2; j++) begin
      int u, a, p, sum;
      u = (j < n) ? int'(cw[addr]) : (s1 ^ s2);
      a = u ^ s1 ^ s2;
      p = a ^ s2;
      if (j >= n || mask[j % MASK_LEN]) expv[ecnt++] = u[0];
      sum = acc + ratio;
      if (sum >= (1 << ACC_W)) expv[ecnt++] = p[0];
      acc = sum % (1 << ACC_W);
      s2 = s1; s1 = a;
      if (j < n) addr = (addr + stride) % n;
    end
    // drive
    check(busy == 1'b0, "R10", {tag, " idle before start"}, busy, 0);
    cfg_k_len = KW'(k); cfg_outer_full = full; cfg_stride = NW'(stride);
    cfg_sys_mask = mask; cfg_keep_ratio = ACC_W'(ratio); info_bits = info;
    gcnt = 0; bcnt = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, "R10", {tag, " accepted at once"}, busy, 1);
    if (poke) begin
      info_bits = ~info; cfg_keep_ratio = ~ACC_W'(ratio); cfg_sys_mask = ~mask;
      cfg_k_len = KW'(3); cfg_outer_full = ~full;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (busy) @(negedge clk);
    check(bcnt == k + 2 * (n + 2), "R9", {tag, " busy cycles"}, bcnt, k + 2 * (n + 2));
    check(gcnt == ecnt, "R5", {tag, " stream length"}, gcnt, ecnt);
    begin
      int bad = -1;
      for (int i = 0; i < ecnt && i < gcnt; i++) if (bad < 0 && got[i] != expv[i]) bad = i;
      check(bad < 0, "R2/R3/R4/R6/R8", {tag, " stream content, first bad index in actual"},
            bad, -1);
    end
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R1", "in reset", {busy, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 1'b0 && out_valid == 1'b0, "R1", "after reset", {busy, out_valid}, 0);
    // R7: only the two closing systematic bits can appear
    run_block(2, 1'b0, 1, 0, 0, 1'b0, "R7 closing only");
    check(gcnt == 2, "R7", "closing bits alone", gcnt, 2);
    run_block(9, 1'b1, 3, 0, 0, 1'b0, "R7 closing full mode");
    // full keep and half keep
    run_block(8, 1'b1, 5, 255, 1, 1'b0, "keep nearly all");
    run_block(9, 1'b0, 5, 128, 2, 1'b0, "R3 odd k rate 2/3");
    run_block(64, 1'b0, 17, 170, 2, 1'b1, "R9 poke while busy");
    // R6: mask wrap, N above the period
    run_block(250, 1'b1, 77, 100, 2, 1'b0, "R6 mask wrap N=500");
    run_block(192, 1'b1, 131, 255, 2, 1'b1, "R6 mask wrap N=384");
    run_block(256, 1'b0, 101, 200, 2, 1'b0, "max k rate 2/3");
    // near-exhaustive sweep of small sizes, both outer modes, back to back
    for (int k = 2; k <= 24; k++)
      for (int f = 0; f < 2; f++)
        run_block(k, f[0], 2 * k + 1, (k * 37 + f * 91) % 256, 2, (k % 5) == 0, "R8 sweep");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule